// File: doc/BRIEF.md
# Chained-Block DMA Command Engine

This engine sits beside a processing element that owns a private local memory and moves data between that memory and a wider remote address space. Each command has a direction: a get copies remote data into local memory, and a put copies local data out. A simple command carries one local address, one remote address and a byte count. A list command instead points at a table of block descriptors in local memory. The engine walks that table, moves each block in turn, and reports completion once for the whole command.

All movement happens in 16-byte beats on a request/acknowledge beat port. The transfer fabric behind that port does the actual copy. Descriptors are read through a second request/acknowledge port into local memory. A list command is checked in full before any beat is issued: the engine first reads every descriptor to validate it, then reads them again to carry out the moves. A bad field anywhere in the command therefore aborts it with no data moved.

Top module: `sgdma_unit`

## Requirements
- R1: After reset, busy, done, err, lm_req and bt_req are 0 and cmd_ready is 1.
- R2: A valid simple command issues size/16 beats. Beat k carries local address laddr+16k (modulo 2^LADDR_W) and remote address raddr+16k. bt_put equals cmd_put (1 = put, local to remote; 0 = get).
- R3: A block size of 0, above 16384, or not a multiple of 16 is rejected. On rejection, done is 1 and err is 1 in the cycle after the command is presented, busy stays 0, and no request is issued. A size of exactly 16384 is accepted.
- R4: A command is rejected in the same way as in R3 if, for a simple command, bits 3:0 of the local or remote address are non-zero, or, for a list command, bits 3:0 of the local address or bits 2:0 of the list address are non-zero.
- R5: A list command with a length outside 2..2048 is rejected in the same way as in R3.
- R6: Descriptor i is read from local address list_addr+8*i. Its bits 31:0 hold the remote address and bits 46:32 hold the block size. Descriptors are read in index order: once in full for validation, then once more in full as the blocks are moved.
- R7: In a list command, the local address of each block continues directly after the end of the previous block. Each block's remote address comes from its own descriptor.
- R8: If any descriptor fails the size rule of R3 or has a non-zero remote address in bits 3:0, the command ends with err=1 and done=1, and no beat is issued.
- R9: busy is 1 from the cycle after acceptance until the final beat acknowledge. In the next cycle, done is 1 for exactly one cycle and busy is 0. There is one done pulse per command.
- R10: While busy, cmd_ready is 0 and cmd_valid has no effect on the running transfer.
- R11: A raised bt_req holds its address and direction fields unchanged until bt_ack is seen.
- R12: err stays 1 until the next command is presented while idle. Acceptance of a valid command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| cmd_valid | input | 1 | command presented this cycle |
| cmd_ready | output | 1 | engine idle, command will be taken |
| cmd_put | input | 1 | 1 = put (local to remote), 0 = get |
| cmd_is_list | input | 1 | 1 = list command |
| cmd_laddr | input | LADDR_W | local start address |
| cmd_raddr | input | 32 | remote address (simple command) |
| cmd_size | input | 15 | block size in bytes (simple command) |
| cmd_list_addr | input | LADDR_W | descriptor table base (list command) |
| cmd_list_len | input | 12 | number of descriptors (list command) |
| busy | output | 1 | command in progress |
| done | output | 1 | one-cycle completion pulse |
| err | output | 1 | last command was rejected or aborted |
| lm_req | output | 1 | descriptor read request |
| lm_addr | output | LADDR_W | descriptor address |
| lm_ack | input | 1 | descriptor read acknowledge, data valid |
| lm_rdata | input | 47 | descriptor bits 46:0 |
| bt_req | output | 1 | beat request |
| bt_put | output | 1 | beat direction |
| bt_laddr | output | LADDR_W | beat local address |
| bt_raddr | output | 32 | beat remote address |
| bt_ack | input | 1 | beat acknowledge |

## Verification
A wrong block counter or address register shows up at the beat port within one acknowledge. The beat count or the next address then differs from the arithmetic value, and a wrong running local address shows on the first beat of the following block. A wrong list index appears at once in the descriptor read address. A faulty validation pass shows up as beats issued for a command that should have died, or as an error flag on a clean list. Completion faults show up within one cycle of the final acknowledge, as a missing, late or doubled done pulse.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int BEAT_SHIFT      = 4;
  localparam int BEAT_BYTES      = 1 << BEAT_SHIFT;
  localparam int SIZE_W          = 15;
  localparam int MAX_BLOCK_BYTES = 16384;
  localparam int BEAT_CNT_W      = SIZE_W - BEAT_SHIFT;
  localparam int LEN_W           = 12;
  localparam int MIN_LIST        = 2;
  localparam int MAX_LIST        = 2048;
  localparam int RADDR_W         = 32;
  localparam int DESC_SHIFT      = 3;
  localparam int DESC_W          = RADDR_W + SIZE_W;

  // descriptor word: size in the upper field, remote address below
  typedef struct packed {
    logic [SIZE_W-1:0]  size;
    logic [RADDR_W-1:0] raddr;
  } desc_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FETCH, ST_MOVE} state_e;

  function automatic logic blk_size_ok(input logic [SIZE_W-1:0] s);
    return (s != '0) && (s <= SIZE_W'(MAX_BLOCK_BYTES)) &&
           (s[BEAT_SHIFT-1:0] == '0);
  endfunction

  function automatic logic [BEAT_CNT_W-1:0] beats_of(input logic [SIZE_W-1:0] s);
    return s[SIZE_W-1:BEAT_SHIFT];
  endfunction

  function automatic logic list_len_ok(input logic [LEN_W-1:0] n);
    return (n >= LEN_W'(MIN_LIST)) && (n <= LEN_W'(MAX_LIST));
  endfunction

  function automatic logic desc_ok(input desc_t d);
    return blk_size_ok(d.size) && (d.raddr[BEAT_SHIFT-1:0] == '0);
  endfunction
endpackage

// File: rtl/sgdma_cmd_check.sv
module sgdma_cmd_check
  import sgdma_pkg::*;
(
  input  logic                  is_list,
  input  logic [BEAT_SHIFT-1:0] laddr_lo,
  input  logic [BEAT_SHIFT-1:0] raddr_lo,
  input  logic [SIZE_W-1:0]     size,
  input  logic [DESC_SHIFT-1:0] list_lo,
  input  logic [LEN_W-1:0]      list_len,
  output logic                  ok
);
  logic single_ok, chain_ok;

  always_comb begin
    single_ok = blk_size_ok(size) && (laddr_lo == '0) && (raddr_lo == '0);
    chain_ok  = list_len_ok(list_len) && (laddr_lo == '0) && (list_lo == '0);
    ok        = is_list ? chain_ok : single_ok;
  end
endmodule

// File: rtl/sgdma_beat_seq.sv
module sgdma_beat_seq
  import sgdma_pkg::*;
#(
  parameter int LADDR_W = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  ld_put,
  input  logic [LADDR_W-1:0]    ld_laddr,
  input  logic [RADDR_W-1:0]    ld_raddr,
  input  logic [BEAT_CNT_W-1:0] ld_beats,
  output logic                  bt_req,
  output logic                  bt_put,
  output logic [LADDR_W-1:0]    bt_laddr,
  output logic [RADDR_W-1:0]    bt_raddr,
  input  logic                  bt_ack,
  output logic                  blk_done
);
  logic                  active_q, put_q;
  logic [LADDR_W-1:0]    la_q;
  logic [RADDR_W-1:0]    ra_q;
  logic [BEAT_CNT_W-1:0] left_q;
  logic                  beat_taken, last_beat;

  assign beat_taken = active_q && bt_ack;
  assign last_beat  = (left_q == BEAT_CNT_W'(1));
  assign blk_done   = beat_taken && last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      put_q    <= 1'b0;
      la_q     <= '0;
      ra_q     <= '0;
      left_q   <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      put_q    <= ld_put;
      la_q     <= ld_laddr;
      ra_q     <= ld_raddr;
      left_q   <= ld_beats;
    end else if (beat_taken) begin
      if (last_beat) begin
        active_q <= 1'b0;
      end else begin
        la_q   <= la_q + LADDR_W'(BEAT_BYTES);
        ra_q   <= ra_q + RADDR_W'(BEAT_BYTES);
        left_q <= left_q - BEAT_CNT_W'(1);
      end
    end
  end

  assign bt_req   = active_q;
  assign bt_put   = put_q;
  assign bt_laddr = la_q;
  assign bt_raddr = ra_q;

  a_r11_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    bt_req && !bt_ack |=> bt_req && $stable(bt_laddr) && $stable(bt_raddr) && $stable(bt_put));
  a_r2_remote_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_taken && !last_beat |=> bt_req && (bt_raddr == $past(bt_raddr) + RADDR_W'(BEAT_BYTES)));
  a_r4_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bt_req |-> (bt_laddr[BEAT_SHIFT-1:0] == '0) && (bt_raddr[BEAT_SHIFT-1:0] == '0));
  a_r9_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active_q);
endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
#(
  parameter int LADDR_W = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic                  cmd_ok,
  input  logic                  cmd_put,
  input  logic                  cmd_is_list,
  input  logic [LADDR_W-1:0]    cmd_laddr,
  input  logic [RADDR_W-1:0]    cmd_raddr,
  input  logic [SIZE_W-1:0]     cmd_size,
  input  logic [LADDR_W-1:0]    cmd_list_addr,
  input  logic [LEN_W-1:0]      cmd_list_len,
  output logic                  cmd_ready,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic                  lm_req,
  output logic [LADDR_W-1:0]    lm_addr,
  input  logic                  lm_ack,
  input  logic [DESC_W-1:0]     lm_rdata,
  output logic                  seq_load,
  output logic                  seq_put,
  output logic [LADDR_W-1:0]    seq_laddr,
  output logic [RADDR_W-1:0]    seq_raddr,
  output logic [BEAT_CNT_W-1:0] seq_beats,
  input  logic                  seq_active,
  input  logic [LADDR_W-1:0]    seq_cur_laddr,
  input  logic                  seq_blk_done
);
  state_e             state_q;
  logic               list_q, dir_q, done_q, err_q;
  logic [LADDR_W-1:0] base_q, laddr_q;
  logic [LEN_W-1:0]   len_q, idx_q;
  desc_t              desc;
  logic               idle, last_idx, good_desc;
  logic               accept_evt, reject_evt, desc_bad_evt, final_evt;

  assign desc      = desc_t'(lm_rdata);
  assign good_desc = desc_ok(desc);
  assign idle      = (state_q == ST_IDLE);
  assign last_idx  = (idx_q == len_q - LEN_W'(1));

  // named events for the checks below
  assign accept_evt   = idle && cmd_valid && cmd_ok;
  assign reject_evt   = idle && cmd_valid && !cmd_ok;
  assign desc_bad_evt = (state_q == ST_SCAN || state_q == ST_FETCH) && lm_ack && !good_desc;
  assign final_evt    = (state_q == ST_MOVE) && seq_blk_done && (!list_q || last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      list_q  <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      base_q  <= '0;
      laddr_q <= '0;
      len_q   <= '0;
      idx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (reject_evt) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else if (accept_evt) begin
            err_q   <= 1'b0;
            dir_q   <= cmd_put;
            list_q  <= cmd_is_list;
            base_q  <= cmd_list_addr;
            len_q   <= cmd_list_len;
            laddr_q <= cmd_laddr;
            idx_q   <= '0;
            state_q <= cmd_is_list ? ST_SCAN : ST_MOVE;
          end
        end
        ST_SCAN: begin
          if (lm_ack) begin
            if (!good_desc) begin
              err_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (last_idx) begin
              idx_q   <= '0;
              state_q <= ST_FETCH;
            end else begin
              idx_q <= idx_q + LEN_W'(1);
            end
          end
        end
        ST_FETCH: begin
          if (lm_ack) begin
            if (!good_desc) begin
              err_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_MOVE;
            end
          end
        end
        ST_MOVE: begin
          if (final_evt) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (seq_blk_done) begin
            idx_q   <= idx_q + LEN_W'(1);
            laddr_q <= seq_cur_laddr + LADDR_W'(BEAT_BYTES);
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    seq_load  = (idle && accept_evt && !cmd_is_list) ||
                ((state_q == ST_FETCH) && lm_ack && good_desc);
    seq_put   = idle ? cmd_put : dir_q;
    seq_laddr = idle ? cmd_laddr : laddr_q;
    seq_raddr = idle ? cmd_raddr : desc.raddr;
    seq_beats = beats_of(idle ? cmd_size : desc.size);
  end

  assign lm_req    = (state_q == ST_SCAN) || (state_q == ST_FETCH);
  assign lm_addr   = base_q + (LADDR_W'(idx_q) << DESC_SHIFT);
  assign cmd_ready = idle;
  assign busy      = !idle;
  assign done      = done_q;
  assign err       = err_q;

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy && !err);
  a_r9_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    final_evt |=> done && !busy);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> done && err && !busy && !seq_active);
  a_r8_abort_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    desc_bad_evt |=> err && done && !seq_active);
  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !lm_req && !seq_active);
  a_r6_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(lm_req && seq_active));
  a_r12_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
    err && !cmd_valid |=> err);
endmodule

// File: rtl/sgdma_unit.sv
module sgdma_unit
  import sgdma_pkg::*;
#(
  parameter int LADDR_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_put,
  input  logic                cmd_is_list,
  input  logic [LADDR_W-1:0]  cmd_laddr,
  input  logic [RADDR_W-1:0]  cmd_raddr,
  input  logic [SIZE_W-1:0]   cmd_size,
  input  logic [LADDR_W-1:0]  cmd_list_addr,
  input  logic [LEN_W-1:0]    cmd_list_len,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                lm_req,
  output logic [LADDR_W-1:0]  lm_addr,
  input  logic                lm_ack,
  input  logic [DESC_W-1:0]   lm_rdata,
  output logic                bt_req,
  output logic                bt_put,
  output logic [LADDR_W-1:0]  bt_laddr,
  output logic [RADDR_W-1:0]  bt_raddr,
  input  logic                bt_ack
);
  logic                  cmd_ok;
  logic                  seq_load, seq_put, seq_blk_done;
  logic [LADDR_W-1:0]    seq_laddr;
  logic [RADDR_W-1:0]    seq_raddr;
  logic [BEAT_CNT_W-1:0] seq_beats;

  sgdma_cmd_check u_check (
    .is_list  (cmd_is_list),
    .laddr_lo (cmd_laddr[BEAT_SHIFT-1:0]),
    .raddr_lo (cmd_raddr[BEAT_SHIFT-1:0]),
    .size     (cmd_size),
    .list_lo  (cmd_list_addr[DESC_SHIFT-1:0]),
    .list_len (cmd_list_len),
    .ok       (cmd_ok)
  );

  sgdma_ctrl #(.LADDR_W(LADDR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ok        (cmd_ok),
    .cmd_put       (cmd_put),
    .cmd_is_list   (cmd_is_list),
    .cmd_laddr     (cmd_laddr),
    .cmd_raddr     (cmd_raddr),
    .cmd_size      (cmd_size),
    .cmd_list_addr (cmd_list_addr),
    .cmd_list_len  (cmd_list_len),
    .cmd_ready     (cmd_ready),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .lm_req        (lm_req),
    .lm_addr       (lm_addr),
    .lm_ack        (lm_ack),
    .lm_rdata      (lm_rdata),
    .seq_load      (seq_load),
    .seq_put       (seq_put),
    .seq_laddr     (seq_laddr),
    .seq_raddr     (seq_raddr),
    .seq_beats     (seq_beats),
    .seq_active    (bt_req),
    .seq_cur_laddr (bt_laddr),
    .seq_blk_done  (seq_blk_done)
  );

  sgdma_beat_seq #(.LADDR_W(LADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (seq_load),
    .ld_put   (seq_put),
    .ld_laddr (seq_laddr),
    .ld_raddr (seq_raddr),
    .ld_beats (seq_beats),
    .bt_req   (bt_req),
    .bt_put   (bt_put),
    .bt_laddr (bt_laddr),
    .bt_raddr (bt_raddr),
    .bt_ack   (bt_ack),
    .blk_done (seq_blk_done)
  );
endmodule

// File: tb/tb_sgdma_unit.sv
module tb_sgdma_unit;
  localparam int LA = 18;
  localparam logic [LA-1:0] LBASE = 18'h01000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_put = 0, cmd_is_list = 0;
  logic [LA-1:0] cmd_laddr = '0, cmd_list_addr = '0;
  logic [31:0] cmd_raddr = '0;
  logic [14:0] cmd_size = '0;
  logic [11:0] cmd_list_len = '0;
  logic cmd_ready, busy, done, err, lm_req, bt_req, bt_put;
  logic [LA-1:0] lm_addr, bt_laddr;
  logic [31:0] bt_raddr;
  logic lm_ack = 0, bt_ack = 0;
  logic [46:0] lm_rdata = '0;

  sgdma_unit #(.LADDR_W(LA)) dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [46:0] dmem [0:2047];
  logic [LA-1:0] lg_la [0:8191];
  logic [31:0]   lg_ra [0:8191];
  logic          lg_put[0:8191];
  int lg_fetch [0:4095];
  int nbeat = 0, nfetch = 0, ndone = 0, stall = 0, bcnt = 0, lcnt = 0;
  logic ack_before = 0, req_d = 0, put_s = 0;
  logic [LA-1:0] la_s = '0;
  logic [31:0] ra_s = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // transfer fabric and descriptor memory model, driven away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      ack_before = bt_ack;
      if (bt_req && req_d && !bt_ack)
        chk(bt_laddr == la_s && bt_raddr == ra_s && bt_put == put_s,
            "R11 fields held while waiting", longint'(bt_raddr), longint'(ra_s));
      req_d = bt_req; la_s = bt_laddr; ra_s = bt_raddr; put_s = bt_put;
      if (done) ndone++;
      bt_ack = 1'b0;
      if (bt_req) begin
        if (bcnt == 0) begin
          bt_ack = 1'b1; bcnt = stall;
          if (nbeat < 8192) begin
            lg_la[nbeat] = bt_laddr; lg_ra[nbeat] = bt_raddr; lg_put[nbeat] = bt_put;
          end
          nbeat++;
        end else bcnt--;
      end
      lm_ack = 1'b0;
      if (lm_req) begin
        if (lcnt == 0) begin
          int ix;
          ix = int'((lm_addr - LBASE) >> 3);
          lm_ack = 1'b1; lcnt = stall;
          lm_rdata = (ix >= 0 && ix < 2048) ? dmem[ix] : '0;
          if (nfetch < 4096) lg_fetch[nfetch] = ix;
          nfetch++;
        end else lcnt--;
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 190000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
    summary();
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic launch(input bit put, input bit lst, input logic [LA-1:0] la,
                        input logic [31:0] ra, input int sz, input int len);
    nbeat = 0; nfetch = 0; ndone = 0;
    cmd_put = put; cmd_is_list = lst; cmd_laddr = la; cmd_raddr = ra;
    cmd_size = 15'(sz); cmd_list_addr = LBASE; cmd_list_len = 12'(len);
    cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int w = 0;
    while (!done && w < 30000) begin step(); w++; end
    chk(done == 1'b1, {tag, " R9 done seen"}, done, 1);
  endtask

  task automatic expect_ok(input bit put, input bit lst, input logic [LA-1:0] la,
                           input logic [31:0] ra, input int sz, input int len, input string tag);
    int n = 0, bad = 0;
    longint off = 0;
    chk(busy == 1'b1 && err == 1'b0, {tag, " R9 busy after accept"}, busy, 1);
    wait_done(tag);
    chk(ack_before == 1'b1 && busy == 1'b0, {tag, " R9 done follows final ack"}, ack_before, 1);
    chk(err == 1'b0, {tag, " R12 err clear"}, err, 0);
    if (!lst) begin
      for (int k = 0; k < sz / 16; k++) begin
        if (lg_la[n] != LA'(la + 16 * k) || lg_ra[n] != ra + 32'(16 * k) || lg_put[n] != put) bad++;
        n++;
      end
      chk(bad == 0, {tag, " R2 beat addresses and direction"}, bad, 0);
    end else begin
      for (int i = 0; i < len; i++) begin
        for (int k = 0; k < int'(dmem[i][46:32]) / 16; k++) begin
          if (n < 8192 && (lg_la[n] != LA'(longint'(la) + off) ||
              lg_ra[n] != dmem[i][31:0] + 32'(16 * k) || lg_put[n] != put)) bad++;
          n++; off += 16;
        end
      end
      chk(bad == 0, {tag, " R7 contiguous local, per-descriptor remote"}, bad, 0);
      bad = 0;
      for (int f = 0; f < 2 * len; f++) if (lg_fetch[f] != f % len) bad++;
      chk(nfetch == 2 * len && bad == 0, {tag, " R6 descriptor order"}, nfetch, 2 * len);
    end
    chk(nbeat == n, {tag, " R2 beat count"}, nbeat, n);
    step();
    chk(done == 1'b0 && ndone == 1, {tag, " R9 one done pulse"}, ndone, 1);
  endtask

  task automatic expect_reject(input string tag);
    chk(done == 1'b1 && err == 1'b1 && busy == 1'b0, {tag, " rejected next cycle"},
        {done, err, busy}, 3'b110);
    for (int i = 0; i < 4; i++) step();
    chk(nbeat == 0 && nfetch == 0 && ndone == 1, {tag, " no transfer"}, nbeat + nfetch, 0);
    chk(err == 1'b1, {tag, " R12 err held"}, err, 1);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) dmem[i] = '0;
    #1;
    chk(busy == 0 && done == 0 && err == 0 && lm_req == 0 && bt_req == 0 && cmd_ready == 1,
        "R1 reset state", {busy, done, err, lm_req, bt_req}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk(busy == 0 && bt_req == 0 && lm_req == 0 && cmd_ready == 1, "R1 after release", busy, 0);

    // R2 sweep of simple commands over size, direction and acknowledge spacing
    for (int s = 0; s < 2; s++) begin
      stall = 2 * s;
      for (int d = 0; d < 2; d++)
        for (int sz = 16; sz <= 512; sz += 16) begin
          launch(d[0], 0, LA'(18'h00200 + sz * 4), 32'h4000_0000 + 32'(sz * 256), sz, 0);
          expect_ok(d[0], 0, LA'(18'h00200 + sz * 4), 32'h4000_0000 + 32'(sz * 256), sz, 0, "R2 sweep");
        end
    end
    stall = 0;
    launch(1, 0, 18'h10000, 32'hC000_0000, 16384, 0);
    expect_ok(1, 0, 18'h10000, 32'hC000_0000, 16384, 0, "R3 max block");
    launch(0, 0, 18'h3FFE0, 32'h0000_1000, 64, 0);
    expect_ok(0, 0, 18'h3FFE0, 32'h0000_1000, 64, 0, "R2 local wrap");

    // R3 size rule, R4 alignment, R5 list length
    launch(0, 0, 18'h100, 32'h100, 0, 0);      expect_reject("R3 size zero");
    launch(0, 0, 18'h100, 32'h100, 24, 0);     expect_reject("R3 size not beat multiple");
    launch(1, 0, 18'h100, 32'h100, 16400, 0);  expect_reject("R3 size above max");
    launch(1, 0, 18'h100, 32'h100, 32752, 0);  expect_reject("R3 size far above max");
    launch(0, 0, 18'h104, 32'h100, 32, 0);     expect_reject("R4 local misaligned");
    launch(0, 0, 18'h100, 32'h108, 32, 0);     expect_reject("R4 remote misaligned");
    launch(0, 1, 18'h100, 32'h0, 0, 1);        expect_reject("R5 list length one");
    launch(0, 1, 18'h100, 32'h0, 0, 0);        expect_reject("R5 list length zero");
    launch(0, 1, 18'h100, 32'h0, 0, 2049);     expect_reject("R5 list length 2049");
    cmd_list_addr = LBASE + 18'd4;
    cmd_is_list = 1; cmd_list_len = 12'd3; cmd_laddr = 18'h100; nbeat = 0; nfetch = 0; ndone = 0;
    cmd_valid = 1; step(); cmd_valid = 0;
    expect_reject("R4 list base misaligned");

    // R12 clear on next accepted command
    launch(0, 0, 18'h200, 32'h2000, 32, 0);
    chk(err == 1'b0, "R12 err cleared by accept", err, 0);
    wait_done("R12"); step();

    // R6 R7 lists of several lengths and spacings
    for (int s = 0; s < 2; s++) begin
      stall = s * 3;
      for (int L = 2; L <= 7; L++) begin
        for (int i = 0; i < L; i++) dmem[i] = {15'(16 * (i + 1 + L)), 32'h8000_0000 + 32'(i * 32'h1_0000)};
        launch(L[0], 1, 18'h02000, 32'h0, 0, L);
        expect_ok(L[0], 1, 18'h02000, 32'h0, 0, L, "R7 list");
      end
    end
    stall = 0;
    for (int i = 0; i < 2048; i++) dmem[i] = {15'd16, 32'h9000_0000 + 32'(i * 64)};
    launch(0, 1, 18'h20000, 32'h0, 0, 2048);
    expect_ok(0, 1, 18'h20000, 32'h0, 0, 2048, "R5 list length 2048");

    // R8 bad descriptor anywhere aborts with no beats
    for (int i = 0; i < 6; i++) dmem[i] = {15'd64, 32'h5000_0000 + 32'(i * 256)};
    dmem[4] = {15'd0, 32'h5000_4000};
    launch(1, 1, 18'h400, 32'h0, 0, 6);
    wait_done("R8");
    chk(err == 1 && nbeat == 0 && nfetch == 5, "R8 zero size descriptor aborts", nbeat, 0);
    step();
    dmem[4] = {15'd64, 32'h5000_4000}; dmem[5] = {15'd64, 32'h5000_4008};
    launch(1, 1, 18'h400, 32'h0, 0, 6);
    wait_done("R8");
    chk(err == 1 && nbeat == 0 && nfetch == 6, "R8 misaligned remote in last descriptor", nbeat, 0);
    step();
    dmem[5] = {15'd16400, 32'h5000_5000};
    launch(0, 1, 18'h400, 32'h0, 0, 6);
    wait_done("R8");
    chk(err == 1 && nbeat == 0, "R8 oversize descriptor", nbeat, 0);
    step();

    // R10 a command presented while busy is ignored
    for (int i = 0; i < 3; i++) dmem[i] = {15'd128, 32'h7000_0000 + 32'(i * 4096)};
    stall = 1;
    launch(1, 1, 18'h08000, 32'h0, 0, 3);
    step(); step();
    chk(cmd_ready == 1'b0, "R10 ready low while busy", cmd_ready, 0);
    cmd_is_list = 0; cmd_put = 0; cmd_laddr = 18'h300; cmd_raddr = 32'h1230; cmd_size = 15'd16;
    cmd_valid = 1; step(); cmd_valid = 0;
    cmd_is_list = 1; cmd_put = 1;
    expect_ok(1, 1, 18'h08000, 32'h0, 0, 3, "R10 ignored while busy");
    stall = 0;

    summary();
  end
endmodule